// File: doc/BRIEF.md
# Promotable Interrupt Priority Resolver

This block chooses which interrupt a CPU sequencer takes next. A bank of maskable request lines comes in, each with its own enable. Every line owns a fixed 16-bit vector address in a table near the top of memory. Among the lines that are pending and enabled, the one with the higher vector address wins. One extra non-maskable input sits above every maskable line.

Software can lift any single maskable line above all the other maskable lines. It does this by writing the low byte of that line's vector address into a promotion register. A global mask input blocks every maskable line but leaves the non-maskable input alone.

The winner is captured only when the sequencer signals that an instruction has finished. Between those strobes the outputs hold still, so the sequencer sees a stable vector at each instruction boundary.

Top module: `irq_resolver`

## Requirements
- R1: While reset is held at a clock edge, take_valid becomes 0, take_vec becomes 0x0000 and the promotion register becomes 0x00, a value that matches no source.
- R2: Maskable source i (bit i of irq_req and irq_en) has vector 0xFFF2 - 2*i, so source 0 is at 0xFFF2 and source 51 is at 0xFF8C. The non-maskable input has vector 0xFFF4.
- R3: With no promotion in force, the winning maskable source is the eligible one with the highest vector address, which is the lowest index.
- R4: A request whose irq_en bit is 0 is never chosen.
- R5: After prio_wdata is written with prio_we, a pending, enabled source whose vector low byte equals that value wins over all other maskable sources. If the promoted source is not eligible, the address order of R3 applies.
- R6: Bit 0 of the promotion value is ignored, so 0xE1 promotes the same source as 0xE0 (source 9, vector 0xFFE0).
- R7: A promotion value that matches no maskable vector has no effect. Examples are 0x02, 0xF4 (the non-maskable vector) and the reset value.
- R8: While int_mask is 1, no maskable request is presented.
- R9: While nmi_req is 1, the latched vector is 0xFFF4 with take_valid 1, regardless of int_mask, promotion or maskable requests.
- R10: take_valid and take_vec change only on a clock edge where insn_done is 1. At that edge they take the result of that cycle's inputs.
- R11: On an insn_done edge with nothing eligible, take_valid becomes 0 and take_vec keeps its previous value.
- R12: A promotion write takes effect from the next cycle on. An insn_done in the same cycle as the write resolves with the old promotion value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| irq_req | input | NUM_SRC | Maskable request lines, bit i is source i |
| irq_en | input | NUM_SRC | Per-line enables |
| nmi_req | input | 1 | Non-maskable request, top priority |
| int_mask | input | 1 | Global mask for maskable lines (1 = masked) |
| prio_we | input | 1 | Write strobe for the promotion register |
| prio_wdata | input | 8 | Low byte of the vector to promote |
| insn_done | input | 1 | Instruction-boundary strobe, latches the winner |
| take_valid | output | 1 | Latched: an interrupt is to be taken |
| take_vec | output | 16 | Latched vector address of the winner |

## Verification
The main function is tried with several request patterns, each answering one question:
- Two pending lines that are far apart show that address order is followed.
- A single request on the lowest-priority line shows the bottom of the table is reachable.
- A pending line with its enable cleared shows the enables are honoured.

Promotion is tried four ways:
- A promoted line that is not pending confirms the fallback to address order.
- A promoted line that is pending confirms it wins.
- An odd low byte confirms that bit 0 is dropped.
- Values that hit no maskable vector confirm the register is then inert, including the non-maskable vector's byte.

Further patterns separate the remaining mechanisms:
- Mask, non-maskable and idle patterns distinguish gating from hold behaviour.
- Writing the promotion register in the same cycle as a strobe separates the old promotion value from the new one.

// File: rtl/irq_res_pkg.sv
// Package irq_res_pkg: shared vector type and the source-to-vector mapping.
// Assumes vectors are word aligned and counted downward from the top entry.
package irq_res_pkg;
    typedef logic [15:0] vec_t;

    // Vector address of maskable source idx, given the top maskable vector.
    function automatic vec_t src_vec(vec_t top, int idx);
        return top - 16'(2 * idx);
    endfunction
endpackage

// File: rtl/irq_prio_reg.sv
// Module irq_prio_reg: holds the promotion byte and decodes which source it names.
// Assumes all maskable vectors share one high byte, so the low byte alone identifies
// a source; bit 0 is dropped because vectors are word aligned.
module irq_prio_reg #(
    parameter int                  NUM_SRC = 52,
    parameter irq_res_pkg::vec_t   VEC_TOP = 16'hFFF2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               prio_we,
    input  logic [7:0]         prio_wdata,
    output logic [NUM_SRC-1:0] promo_hit
);
    logic [7:0] prio_q;

    // Promotion byte register, cleared to a value that names no source.
    always_ff @(posedge clk) begin
        if (!rst_n)       prio_q <= 8'h00;
        else if (prio_we) prio_q <= prio_wdata;
    end

    // One comparator per source against its own vector low byte.
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_match
        localparam irq_res_pkg::vec_t V = irq_res_pkg::src_vec(VEC_TOP, g);
        assign promo_hit[g] = (prio_q[7:1] == V[7:1]);
    end

    // R7: distinct vectors mean at most one source can match the promotion value.
    a_r7_single_match: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(promo_hit));
endmodule

// File: rtl/irq_pick.sv
// Module irq_pick: combinational winner selection.
// Order: non-maskable, then the promoted source, then the highest vector address.
// Assumes promo_hit is one-hot or zero.
module irq_pick #(
    parameter int                  NUM_SRC = 52,
    parameter irq_res_pkg::vec_t   VEC_TOP = 16'hFFF2,
    parameter irq_res_pkg::vec_t   NMI_VEC = 16'hFFF4
) (
    input  logic               nmi_req,
    input  logic               int_mask,
    input  logic [NUM_SRC-1:0] irq_req,
    input  logic [NUM_SRC-1:0] irq_en,
    input  logic [NUM_SRC-1:0] promo_hit,
    output logic               win_any,
    output irq_res_pkg::vec_t  win_vec
);
    localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

    logic [NUM_SRC-1:0] elig;
    logic               nat_found, pro_found;
    logic [IDX_W-1:0]   nat_idx, pro_idx;

    // Eligible lines: pending, enabled and not globally masked.
    assign elig = irq_req & irq_en & {NUM_SRC{~int_mask}};

    // Scan downward so the lowest index (highest address) is kept last.
    always_comb begin
        nat_found = 1'b0;
        nat_idx   = '0;
        pro_found = 1'b0;
        pro_idx   = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (elig[i]) begin
                nat_found = 1'b1;
                nat_idx   = IDX_W'(i);
            end
            if (elig[i] && promo_hit[i]) begin
                pro_found = 1'b1;
                pro_idx   = IDX_W'(i);
            end
        end
    end

    // Final selection across the three priority tiers.
    always_comb begin
        win_any = nmi_req | pro_found | nat_found;
        if (nmi_req)        win_vec = NMI_VEC;
        else if (pro_found) win_vec = irq_res_pkg::src_vec(VEC_TOP, int'(pro_idx));
        else                win_vec = irq_res_pkg::src_vec(VEC_TOP, int'(nat_idx));
    end
endmodule

// File: rtl/irq_take_latch.sv
// Module irq_take_latch: captures the winner at an instruction boundary.
// Assumes win_vec is meaningful only while win_any is high.
module irq_take_latch (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              insn_done,
    input  logic              win_any,
    input  irq_res_pkg::vec_t win_vec,
    output logic              take_valid,
    output irq_res_pkg::vec_t take_vec
);
    // Update the flag on each strobe; update the vector only when there is a winner.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            take_valid <= 1'b0;
            take_vec   <= '0;
        end else if (insn_done) begin
            take_valid <= win_any;
            if (win_any) take_vec <= win_vec;
        end
    end

    // R10: outputs are frozen between strobes.
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !insn_done |=> ($stable(take_valid) && $stable(take_vec)));

    // R11: an empty strobe drops the flag and keeps the vector.
    a_r11_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_done && !win_any) |=> (!take_valid && $stable(take_vec)));
endmodule

// File: rtl/irq_resolver.sv
// Module irq_resolver: top of the promotable interrupt priority resolver.
// Assumes NUM_SRC <= 128 so that every maskable vector has a distinct low byte.
module irq_resolver #(
    parameter int                  NUM_SRC = 52,
    parameter irq_res_pkg::vec_t   VEC_TOP = 16'hFFF2,
    parameter irq_res_pkg::vec_t   NMI_VEC = 16'hFFF4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_req,
    input  logic [NUM_SRC-1:0] irq_en,
    input  logic               nmi_req,
    input  logic               int_mask,
    input  logic               prio_we,
    input  logic [7:0]         prio_wdata,
    input  logic               insn_done,
    output logic               take_valid,
    output logic [15:0]        take_vec
);
    logic [NUM_SRC-1:0] promo_hit;
    logic               win_any;
    irq_res_pkg::vec_t  win_vec;

    irq_prio_reg #(.NUM_SRC(NUM_SRC), .VEC_TOP(VEC_TOP)) u_prio (
        .clk        (clk),
        .rst_n      (rst_n),
        .prio_we    (prio_we),
        .prio_wdata (prio_wdata),
        .promo_hit  (promo_hit)
    );

    irq_pick #(.NUM_SRC(NUM_SRC), .VEC_TOP(VEC_TOP), .NMI_VEC(NMI_VEC)) u_pick (
        .nmi_req   (nmi_req),
        .int_mask  (int_mask),
        .irq_req   (irq_req),
        .irq_en    (irq_en),
        .promo_hit (promo_hit),
        .win_any   (win_any),
        .win_vec   (win_vec)
    );

    irq_take_latch u_latch (
        .clk        (clk),
        .rst_n      (rst_n),
        .insn_done  (insn_done),
        .win_any    (win_any),
        .win_vec    (win_vec),
        .take_valid (take_valid),
        .take_vec   (take_vec)
    );

    // R9: a non-maskable request at a strobe is always taken at its own vector.
    a_r9_nmi: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_done && nmi_req) |=> (take_valid && take_vec == NMI_VEC));

    // R8: with the mask set and no non-maskable request, nothing is taken.
    a_r8_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_done && int_mask && !nmi_req) |=> !take_valid);
endmodule

// File: tb/test_irq_resolver.sv
// Bench for irq_resolver: a vector table walked in order, then directed cases.
module test_irq_resolver;
    localparam int N = 52;

    typedef struct packed {
        logic [7:0]  prio;
        logic [63:0] req;
        logic [63:0] en;
        logic        mask;
        logic        nmi;
        logic        ev;
        logic [15:0] evec;
        logic [7:0]  rq;
    } row_t;

    localparam logic [63:0] ALL = 64'hFFFF_FFFF_FFFF_FFFF;
    localparam int NROW = 13;
    localparam row_t TBL [NROW] = '{
        '{8'h00, 64'h21,                  ALL,                    1'b0, 1'b0, 1'b1, 16'hFFF2, 8'd3},
        '{8'h00, 64'h10_0020,             ALL,                    1'b0, 1'b0, 1'b1, 16'hFFE8, 8'd3},
        '{8'hE0, 64'h10_0020,             ALL,                    1'b0, 1'b0, 1'b1, 16'hFFE8, 8'd5},
        '{8'hE0, 64'h220,                 ALL,                    1'b0, 1'b0, 1'b1, 16'hFFE0, 8'd5},
        '{8'hE1, 64'h220,                 ALL,                    1'b0, 1'b0, 1'b1, 16'hFFE0, 8'd6},
        '{8'h02, 64'h220,                 ALL,                    1'b0, 1'b0, 1'b1, 16'hFFE8, 8'd7},
        '{8'h00, 64'h0008_0000_0000_0000, ALL,                    1'b0, 1'b0, 1'b1, 16'hFF8C, 8'd2},
        '{8'h00, 64'h20,                  64'hFFFF_FFFF_FFFF_FFDF, 1'b0, 1'b0, 1'b0, 16'hFF8C, 8'd4},
        '{8'h00, 64'h1,                   ALL,                    1'b1, 1'b0, 1'b0, 16'hFF8C, 8'd8},
        '{8'h00, 64'h1,                   ALL,                    1'b1, 1'b1, 1'b1, 16'hFFF4, 8'd9},
        '{8'hF2, 64'h1,                   ALL,                    1'b0, 1'b1, 1'b1, 16'hFFF4, 8'd9},
        '{8'h8C, 64'h0008_0000_0000_0001, ALL,                    1'b0, 1'b0, 1'b1, 16'hFF8C, 8'd5},
        '{8'hF4, 64'h9,                   ALL,                    1'b0, 1'b0, 1'b1, 16'hFFF2, 8'd7}
    };

    logic         clk = 1'b0;
    logic         rst_n;
    logic [N-1:0] irq_req, irq_en;
    logic         nmi_req, int_mask, prio_we, insn_done;
    logic [7:0]   prio_wdata;
    logic         take_valid;
    logic [15:0]  take_vec;
    int           n_chk = 0, n_bad = 0;
    bit           done = 1'b0;

    always #10 clk = ~clk;

    irq_resolver i_irq_resolver (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_en(irq_en),
        .nmi_req(nmi_req), .int_mask(int_mask), .prio_we(prio_we),
        .prio_wdata(prio_wdata), .insn_done(insn_done),
        .take_valid(take_valid), .take_vec(take_vec)
    );

    task automatic check(input logic ev, input logic [15:0] evec, input string rq);
        n_chk++;
        if (take_valid !== ev || take_vec !== evec) begin
            n_bad++;
            $display("FAIL %s: got valid=%0b vec=%h, expected valid=%0b vec=%h",
                     rq, take_valid, take_vec, ev, evec);
        end
    endtask

    task automatic write_prio(input logic [7:0] v);
        @(negedge clk); prio_we = 1'b1; prio_wdata = v;
        @(negedge clk); prio_we = 1'b0;
    endtask

    task automatic strobe();
        @(negedge clk); insn_done = 1'b1;
        @(negedge clk); insn_done = 1'b0;
    endtask

    initial begin
        rst_n = 1'b0; irq_req = '0; irq_en = '1; nmi_req = 1'b0; int_mask = 1'b0;
        prio_we = 1'b0; prio_wdata = 8'h00; insn_done = 1'b0;
        repeat (3) @(negedge clk);
        check(1'b0, 16'h0000, "R1 reset outputs");
        rst_n = 1'b1;

        // Table walk: R2 R3 R4 R5 R6 R7 R8 R9 R11.
        for (int k = 0; k < NROW; k++) begin
            write_prio(TBL[k].prio);
            @(negedge clk);
            irq_req  = TBL[k].req[N-1:0];
            irq_en   = TBL[k].en[N-1:0];
            int_mask = TBL[k].mask;
            nmi_req  = TBL[k].nmi;
            strobe();
            check(TBL[k].ev, TBL[k].evec, $sformatf("R%0d table row %0d", TBL[k].rq, k));
        end

        // R10: inputs change without a strobe; outputs must not move.
        @(negedge clk);
        nmi_req = 1'b0; int_mask = 1'b0; irq_en = '1; irq_req = 52'h4;
        repeat (3) @(negedge clk);
        check(1'b1, 16'hFFF2, "R10 hold without strobe");

        // R11: empty strobe keeps the vector.
        irq_req = '0;
        strobe();
        check(1'b0, 16'hFFF2, "R11 empty strobe");

        // R12: promotion write in the same cycle as a strobe uses the old value.
        write_prio(8'h00);
        @(negedge clk);
        irq_req = 52'h220;
        prio_we = 1'b1; prio_wdata = 8'hE0; insn_done = 1'b1;
        @(negedge clk);
        prio_we = 1'b0; insn_done = 1'b0;
        check(1'b1, 16'hFFE8, "R12 same-cycle write uses old value");
        strobe();
        check(1'b1, 16'hFFE0, "R12 write effective afterwards");

        // R1: reset clears the promotion register back to a no-match value.
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        check(1'b0, 16'h0000, "R1 reset after activity");
        rst_n = 1'b1;
        strobe();
        check(1'b1, 16'hFFE8, "R1 promotion cleared by reset");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule